// File: doc/BRIEF.md
# Two-Stage Escalating Watchdog Timer

This block is a watchdog timer that measures time against a free-running system counter supplied on an input port. Software reaches it through a small word-addressed bus that carries a one-bit frame select. One frame is for refresh only. The other frame holds control, status, the timeout offset and the compare deadline. Every refresh places the deadline one offset ahead of the current counter value.

When the counter reaches the deadline, the block raises a first warning level and moves the deadline one more offset forward. If the deadline is reached a second time with no refresh, the block raises a second, final level. The first level is meant to drive an interrupt, and the second drives a system reset request. A zero offset makes both levels rise within a few cycles, so software can use it to force an immediate reset.

Both levels are sticky. They fall only on a refresh or on a reset. Any write to the control/status word counts as a refresh, and a write of zero to that word also turns the timer off.

Top module: `wdt_top`

## Requirements
- R1: After reset the enable bit, both warning levels, the offset and the 64-bit compare value read as zero, and `ws0Out` and `ws1Out` are low.
- R2: A write of any data to refresh-frame offset 0x000 clears both warning levels and sets the compare value to the sampled counter plus the offset.
- R3: A write to control-frame offset 0x000 loads the enable bit from data bit 0 and also refreshes. Writing zero disables the timer and clears both levels.
- R4: With offset N ≥ 1, when the last refresh sampled counter value C, the first level (status bit 1, `ws0Out`) is first seen high while the counter reads C+N+1.
- R5: With no further refresh, the second level (status bit 2, `ws1Out`) rises N counter ticks after the first level, at counter C+2N+1. It is never high while the first level is low.
- R6: While enable is 0, neither level rises, even when the counter is at or past the compare value.
- R7: Writes to control-frame offsets 0x010 (low word) and 0x014 (high word) replace the compare value directly. The first level then rises once the counter reaches the new value, and the second level rises one offset later.
- R8: With offset zero, the first level rises on the second clock edge after the refreshing write and the second level rises on the edge after that.
- R9: Reads return data one cycle after the request with `rdValid` high. The status word reads {ws1, ws0, enable} in bits 2..0, the offset sits at 0x008, the interface ID constant at 0xFCC and the part ID constant at 0xFD0 in both frames, and writes to the ID words have no effect.
- R10: Once a level is high it stays high until a refresh or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sysCount | input | CNT_W | Free-running system counter |
| reqValid | input | 1 | Bus request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqFrame | input | 1 | 0 = control frame, 1 = refresh frame |
| reqAddr | input | 12 | Byte offset within the frame |
| wrData | input | 32 | Write data |
| rdValid | output | 1 | Read data valid (one cycle after the read) |
| rdData | output | 32 | Read data |
| ws0Out | output | 1 | First-stage warning level |
| ws1Out | output | 1 | Second-stage warning level |

## Verification
The assertions check on every cycle that a refresh clears both levels and re-arms the deadline from the sampled counter, and that a first-level rise reloads the deadline. They also check that the second level never stands without the first, that neither level rises while the timer is disabled, that both levels hold until a refresh, and that every read gets its valid pulse. The exact counter values at which each level appears, including the zero-offset case and a deadline written directly by software, can only be shown by the bench's timed scenarios. The same holds for register readback and the ignored writes to the ID words.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FRAME_AW = 12;

  localparam logic [FRAME_AW-1:0] OFS_STATUS   = 12'h000;
  localparam logic [FRAME_AW-1:0] OFS_OFFSET   = 12'h008;
  localparam logic [FRAME_AW-1:0] OFS_CMP_LO   = 12'h010;
  localparam logic [FRAME_AW-1:0] OFS_CMP_HI   = 12'h014;
  localparam logic [FRAME_AW-1:0] OFS_KICK     = 12'h000;
  localparam logic [FRAME_AW-1:0] OFS_IFACE_ID = 12'hFCC;
  localparam logic [FRAME_AW-1:0] OFS_PART_ID  = 12'hFD0;

  typedef enum logic {
    FRAME_CTRL    = 1'b0,
    FRAME_REFRESH = 1'b1
  } wdtFrame_e;

  // Strobes from the bus decode to the timing datapath
  typedef struct packed {
    logic refresh;
    logic enableWr;
    logic offsetWr;
    logic cmpLoWr;
    logic cmpHiWr;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter logic [31:0] IFACE_ID = 32'h0001_0A5C,
  parameter logic [31:0] PART_ID  = 32'h0002_7D11
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic                reqFrame,
  input  logic [FRAME_AW-1:0] reqAddr,
  input  logic                enable,
  input  logic                ws0,
  input  logic                ws1,
  input  logic [WORD_W-1:0]   offsetVal,
  input  logic [CNT_W-1:0]    cmpVal,
  output wdtStrobes_t         strobes,
  output logic                rdValid,
  output logic [WORD_W-1:0]   rdData
);
  localparam int unsigned PAD_W = 64;

  logic isWr;
  logic isRd;
  logic inCtrl;
  logic inRefresh;
  logic idHitIface;
  logic idHitPart;
  logic [PAD_W-1:0] cmpWide;
  logic [WORD_W-1:0] readMux;

  assign isWr      = reqValid && reqWrite;
  assign isRd      = reqValid && !reqWrite;
  assign inCtrl    = (wdtFrame_e'(reqFrame) == FRAME_CTRL);
  assign inRefresh = (wdtFrame_e'(reqFrame) == FRAME_REFRESH);
  assign idHitIface = (reqAddr == OFS_IFACE_ID);
  assign idHitPart  = (reqAddr == OFS_PART_ID);
  assign cmpWide   = PAD_W'(cmpVal);

  // Write decode: a status-word write is also a refresh
  always_comb begin
    strobes          = '0;
    strobes.refresh  = isWr && ((inRefresh && reqAddr == OFS_KICK) ||
                                (inCtrl && reqAddr == OFS_STATUS));
    strobes.enableWr = isWr && inCtrl && (reqAddr == OFS_STATUS);
    strobes.offsetWr = isWr && inCtrl && (reqAddr == OFS_OFFSET);
    strobes.cmpLoWr  = isWr && inCtrl && (reqAddr == OFS_CMP_LO);
    strobes.cmpHiWr  = isWr && inCtrl && (reqAddr == OFS_CMP_HI);
  end

  // Read selection; ID words appear in both frames
  always_comb begin
    readMux = '0;
    if (idHitIface) begin
      readMux = IFACE_ID;
    end else if (idHitPart) begin
      readMux = PART_ID;
    end else if (inCtrl) begin
      unique case (reqAddr)
        OFS_STATUS: readMux = {29'd0, ws1, ws0, enable};
        OFS_OFFSET: readMux = offsetVal;
        OFS_CMP_LO: readMux = cmpWide[31:0];
        OFS_CMP_HI: readMux = cmpWide[63:32];
        default:    readMux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= isRd;
      if (isRd) rdData <= readMux;
    end
  end

  // R9: every read is answered on the following cycle
  a_r9_read_answered: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rdValid);
  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> !rdValid);
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  sysCount,
  input  wdtStrobes_t       strobes,
  input  logic [WORD_W-1:0] wrData,
  output logic              enable,
  output logic              ws0,
  output logic              ws1,
  output logic [WORD_W-1:0] offsetVal,
  output logic [CNT_W-1:0]  cmpVal
);
  localparam int unsigned PAD_W = 64;

  logic [CNT_W-1:0] deadline;
  logic             expired;
  logic [PAD_W-1:0] cmpWide;
  logic [CNT_W-1:0] cmpWritten;

  assign deadline = sysCount + CNT_W'(offsetVal);
  assign expired  = enable && (sysCount >= cmpVal);

  // Software write of the compare value, word by word
  always_comb begin
    cmpWide = PAD_W'(cmpVal);
    if (strobes.cmpLoWr) cmpWide[31:0]  = wrData;
    if (strobes.cmpHiWr) cmpWide[63:32] = wrData;
    cmpWritten = cmpWide[CNT_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enable    <= 1'b0;
      ws0       <= 1'b0;
      ws1       <= 1'b0;
      offsetVal <= '0;
      cmpVal    <= '0;
    end else begin
      if (strobes.offsetWr) offsetVal <= wrData;
      if (strobes.enableWr) enable <= wrData[0];
      if (strobes.refresh) begin
        cmpVal <= deadline;
        ws0    <= 1'b0;
        ws1    <= 1'b0;
      end else if (strobes.cmpLoWr || strobes.cmpHiWr) begin
        cmpVal <= cmpWritten;
      end else if (expired) begin
        if (!ws0) begin
          ws0    <= 1'b1;
          cmpVal <= deadline;
        end else begin
          ws1 <= 1'b1;
        end
      end
    end
  end

  a_r3_refresh_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refresh |=> (!ws0 && !ws1));
  a_r2_refresh_rearms: assert property (@(posedge clk) disable iff (!rstN)
    strobes.refresh |=> (cmpVal == $past(sysCount) + CNT_W'($past(offsetVal))));
  a_r4_stage_one_reloads: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ws0) |-> (cmpVal == $past(sysCount) + CNT_W'($past(offsetVal))));
  a_r5_stage_order: assert property (@(posedge clk) disable iff (!rstN)
    ws1 |-> ws0);
  a_r6_ws0_quiet_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !ws0) |=> !ws0);
  a_r6_ws1_quiet_disabled: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !ws1) |=> !ws1);
  a_r10_ws0_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ws0 && !strobes.refresh) |=> ws0);
  a_r10_ws1_holds: assert property (@(posedge clk) disable iff (!rstN)
    (ws1 && !strobes.refresh) |=> ws1);
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W    = 64,
  parameter logic [31:0] IFACE_ID = 32'h0001_0A5C,
  parameter logic [31:0] PART_ID  = 32'h0002_7D11
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] sysCount,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic             reqFrame,
  input  logic [11:0]      reqAddr,
  input  logic [31:0]      wrData,
  output logic             rdValid,
  output logic [31:0]      rdData,
  output logic             ws0Out,
  output logic             ws1Out
);
  wdtStrobes_t       strobes;
  logic              enable;
  logic              ws0;
  logic              ws1;
  logic [WORD_W-1:0] offsetVal;
  logic [CNT_W-1:0]  cmpVal;

  wdt_ctrl #(
    .CNT_W   (CNT_W),
    .IFACE_ID(IFACE_ID),
    .PART_ID (PART_ID)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqFrame (reqFrame),
    .reqAddr  (reqAddr),
    .enable   (enable),
    .ws0      (ws0),
    .ws1      (ws1),
    .offsetVal(offsetVal),
    .cmpVal   (cmpVal),
    .strobes  (strobes),
    .rdValid  (rdValid),
    .rdData   (rdData)
  );

  wdt_datapath #(
    .CNT_W(CNT_W)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .sysCount (sysCount),
    .strobes  (strobes),
    .wrData   (wrData),
    .enable   (enable),
    .ws0      (ws0),
    .ws1      (ws1),
    .offsetVal(offsetVal),
    .cmpVal   (cmpVal)
  );

  assign ws0Out = ws0;
  assign ws1Out = ws1;
endmodule

// File: tb/tb_wdt_top.sv
module tb_wdt_top;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] IFACE_ID = 32'h0001_0A5C;
  localparam logic [31:0] PART_ID  = 32'h0002_7D11;
  localparam int WATCHDOG_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] tbCount = '0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqFrame = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdValid;
  logic [31:0] rdData;
  logic        ws0Out;
  logic        ws1Out;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] exp; string tag; } rdItem_t;
  typedef struct { int kind; logic [63:0] at; string tag; } evItem_t;
  rdItem_t readQ[$];
  evItem_t evQ[$];
  logic prevWs0 = 1'b0;
  logic prevWs1 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always_ff @(posedge clk) tbCount <= tbCount + 64'd1;

  wdt_top #(.CNT_W(64), .IFACE_ID(IFACE_ID), .PART_ID(PART_ID)) dut (
    .clk(clk), .rstN(rstN), .sysCount(tbCount),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqFrame(reqFrame),
    .reqAddr(reqAddr), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .ws0Out(ws0Out), .ws1Out(ws1Out)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic frame, input logic [11:0] a, input logic [31:0] d,
                          output logic [63:0] c);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqFrame = frame; reqAddr = a; wrData = d;
    c = tbCount;
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic busRead(input logic frame, input logic [11:0] a, input logic [31:0] exp,
                         input string tag);
    rdItem_t it;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqFrame = frame; reqAddr = a;
    it.exp = exp; it.tag = tag;
    readQ.push_back(it);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectRise(input int kind, input logic [63:0] at, input string tag);
    evItem_t e;
    e.kind = kind; e.at = at; e.tag = tag;
    evQ.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic onRise(input int kind);
    evItem_t e;
    if (evQ.size() == 0) begin
      chk(1'b0, kind == 0 ? "R6 unexpected ws0 rise" : "R6 unexpected ws1 rise", tbCount, 64'd0);
    end else begin
      e = evQ.pop_front();
      if (e.kind != kind) chk(1'b0, {e.tag, " wrong stage"}, 64'(kind), 64'(e.kind));
      else chk(tbCount == e.at, e.tag, tbCount, e.at);
    end
  endtask

  // Monitor: compares design results against the scoreboard queues
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        if (readQ.size() == 0) begin
          chk(1'b0, "R9 unexpected rdValid", 64'(rdData), 64'd0);
        end else begin
          rdItem_t it;
          it = readQ.pop_front();
          chk(rdData == it.exp, it.tag, 64'(rdData), 64'(it.exp));
        end
      end
      if (ws0Out && !prevWs0) onRise(0);
      if (ws1Out && !prevWs1) onRise(1);
    end
    prevWs0 = ws0Out;
    prevWs1 = ws1Out;
  end

  task automatic runAll();
    logic [63:0] c;
    logic [63:0] c2;
    // Reset state
    idle(3);
    rstN = 1'b1;
    idle(1);
    chk(ws0Out == 1'b0 && ws1Out == 1'b0, "R1 outputs low after reset", {ws1Out, ws0Out}, 0);
    busRead(1'b0, 12'h000, 32'd0, "R1 status zero");
    busRead(1'b0, 12'h008, 32'd0, "R1 offset zero");
    busRead(1'b0, 12'h010, 32'd0, "R1 compare low zero");
    busRead(1'b0, 12'h014, 32'd0, "R1 compare high zero");
    busRead(1'b0, 12'hFCC, IFACE_ID, "R9 iface id control frame");
    busRead(1'b1, 12'hFD0, PART_ID, "R9 part id refresh frame");

    // Full two-stage timeout with offset 20
    busWrite(1'b0, 12'h008, 32'd20, c);
    busRead(1'b0, 12'h008, 32'd20, "R9 offset readback");
    busWrite(1'b0, 12'h000, 32'd1, c);
    expectRise(0, c + 64'd21, "R4 ws0 after offset");
    expectRise(1, c + 64'd41, "R5 ws1 after second offset");
    busRead(1'b0, 12'h000, 32'd1, "R3 enable bit set");
    idle(45);
    busRead(1'b0, 12'h000, 32'd7, "R9 status shows both levels");
    idle(2);
    chk(ws0Out && ws1Out, "R10 levels held", {ws1Out, ws0Out}, 3);

    // Refresh through the refresh frame with arbitrary data
    busWrite(1'b1, 12'h000, 32'hDEAD_BEEF, c);
    busRead(1'b0, 12'h000, 32'd1, "R2 refresh clears levels");
    busRead(1'b0, 12'h010, c[31:0] + 32'd20, "R2 compare rearmed");
    idle(3);
    busWrite(1'b1, 12'h000, 32'd0, c2);
    expectRise(0, c2 + 64'd21, "R2 ws0 after re-refresh");
    idle(25);
    chk(ws0Out && !ws1Out, "R5 ws1 not yet risen", {ws1Out, ws0Out}, 1);
    busWrite(1'b0, 12'h000, 32'd0, c);
    chk(!ws0Out && !ws1Out, "R3 disable write clears", {ws1Out, ws0Out}, 0);
    idle(60);
    busRead(1'b0, 12'h000, 32'd0, "R3 disabled stays quiet");

    // Direct compare write
    busWrite(1'b0, 12'h000, 32'd1, c);
    busWrite(1'b0, 12'h010, c[31:0] + 32'd8, c2);
    expectRise(0, c + 64'd9, "R7 ws0 at written compare");
    expectRise(1, c + 64'd29, "R7 ws1 one offset later");
    idle(35);
    busWrite(1'b0, 12'h000, 32'd0, c);

    // Zero offset forces fastest expiry
    busWrite(1'b0, 12'h008, 32'd0, c);
    busWrite(1'b0, 12'h000, 32'd1, c);
    expectRise(0, c + 64'd2, "R8 ws0 zero offset");
    expectRise(1, c + 64'd3, "R8 ws1 zero offset");
    idle(6);
    busRead(1'b0, 12'h000, 32'd7, "R8 both levels after zero offset");
    busWrite(1'b0, 12'h000, 32'd0, c);

    // Disabled with a passed deadline
    busWrite(1'b0, 12'h010, 32'd0, c);
    busWrite(1'b0, 12'h014, 32'd0, c);
    idle(20);
    busRead(1'b0, 12'h000, 32'd0, "R6 no rise while disabled");
    chk(!ws0Out && !ws1Out, "R6 pins low while disabled", {ws1Out, ws0Out}, 0);

    // ID words are read-only
    busWrite(1'b0, 12'hFCC, 32'h1234_5678, c);
    busWrite(1'b1, 12'hFD0, 32'h8765_4321, c);
    busRead(1'b1, 12'hFCC, IFACE_ID, "R9 iface id unchanged");
    busRead(1'b0, 12'hFD0, PART_ID, "R9 part id unchanged");
    idle(4);
  endtask

  initial begin
    fork
      runAll();
      begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
      end
    join_any
    disable fork;
    chk(readQ.size() == 0, "R9 reads left unanswered", 64'(readQ.size()), 0);
    chk(evQ.size() == 0, "R4 expected level rises missing", 64'(evQ.size()), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule